// File: doc/BRIEF.md
# Audio Serial Frame Transmitter

This block takes parallel audio sample words and sends them as a serial bit stream, one frame for each period of the word strobe. Its timing comes from two pins: a bit clock and a word strobe. Either can be driven by an on-chip clock generator or by an external converter acting as timing master. In both cases the block only listens to them. The bit clock and word strobe are oversampled by the block's system clock, and all state changes occur on system clock edges.

A frame begins when the word strobe shows an edge of the programmed polarity at a bit-clock sampling edge. On the next edge of the opposite bit-clock direction, the block puts out the first bit of the frame. Each later edge of that direction puts out one more bit. The frame word is the sample placed in the upper bits of a frame-wide register, with zero fill below it, and it is sent most significant bit first.

Samples arrive through a one-entry valid/ready slot. One sample is taken at each frame start. If the slot is empty at a frame start, the previous sample is sent again and a sticky underrun flag is raised.

Top module: `audio_framer`

## Requirements
- R1: After reset, `sd_o` is 0, `urun_o` is 0 and `in_ready_o` is 1.
- R2: With `cfg_pol_i`=1, a frame starts when the strobe sampled at a sampling edge is 1 and the strobe at the previous sampling edge was 0. With `cfg_pol_i`=0 the levels are reversed. A strobe edge in the other direction starts nothing.
- R3: With `cfg_edge_i`=0, the strobe is sampled on rising bit-clock edges and `sd_o` changes only after falling edges. With `cfg_edge_i`=1 the directions are swapped. Frame bit 0 appears after the first changing edge that follows the frame start, and `sd_o` stays constant across sampling edges.
- R4: A frame holds `cfg_len_i`+1 bits. After the last bit, `sd_o` is 0 until the next frame.
- R5: The frame word is the sample placed in the most significant SAMPLE_W bits of a FRAME_MAX-bit word, with all lower bits 0. Frame bit k is bit FRAME_MAX-1-k of that word.
- R6: A word is accepted on a cycle where `in_valid_i` and `in_ready_o` are both 1. `in_ready_o` then stays 0 until a frame start takes the word.
- R7: If the slot is empty at a frame start, the previous frame's sample is sent again and `urun_o` goes to 1. It stays 1 until `urun_clr_i` is pulsed. If a new underrun occurs in the same cycle as the clear, the set wins.
- R8: A frame start that arrives before the current frame is complete aborts that frame. The next changing edge sends bit 0 of the newly taken sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| sck_i | input | 1 | Bit clock pin |
| ws_i | input | 1 | Word strobe pin |
| cfg_pol_i | input | 1 | Frame-start strobe polarity: 1 rising, 0 falling |
| cfg_edge_i | input | 1 | 0: sample on rising edges, shift on falling edges; 1: the reverse |
| cfg_len_i | input | LEN_W | Frame length minus one |
| in_valid_i | input | 1 | Sample word offered |
| in_ready_o | output | 1 | Slot is empty and can take a word |
| in_data_i | input | SAMPLE_W | Sample word |
| urun_clr_i | input | 1 | Clears the underrun flag |
| urun_o | output | 1 | Sticky underrun flag |
| sd_o | output | 1 | Serial data output |

## Verification
The bench uses the default SAMPLE_W=8 and FRAME_MAX=16, so the frame length field has only sixteen values. This allows a full sweep over every length, both strobe polarities and both clock-edge modes, 64 configurations in total. Each one covers frames shorter than, equal to and longer than the sample, so the zero fill and the silent tail after a frame are both observed. Dedicated runs cover a strobe restart in the middle of a frame, and an underrun that repeats the sample, followed by clearing the flag.

// File: rtl/audio_framer_pkg.sv
package audio_framer_pkg;
  typedef enum logic {
    SMP_ON_RISE = 1'b0,
    SMP_ON_FALL = 1'b1
  } edge_mode_e;
endpackage

// File: rtl/audio_framer_edges.sv
module audio_framer_edges
  import audio_framer_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic sck_i,
  input  logic ws_i,
  input  logic cfg_pol_i,
  input  logic cfg_edge_i,
  output logic smp_stb_o,
  output logic launch_stb_o,
  output logic start_o
);
  logic sck_q, sck_d, ws_q, ws_last, ws_seen;
  logic rise, fall;
  edge_mode_e mode;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q   <= 1'b0;
      sck_d   <= 1'b0;
      ws_q    <= 1'b0;
      ws_last <= 1'b0;
      ws_seen <= 1'b0;
    end else begin
      sck_q <= sck_i;
      sck_d <= sck_q;
      ws_q  <= ws_i;
      if (smp_stb_o) begin
        ws_last <= ws_q;
        ws_seen <= 1'b1;
      end
    end
  end

  always_comb begin
    mode         = edge_mode_e'(cfg_edge_i);
    rise         = sck_q & ~sck_d;
    fall         = ~sck_q & sck_d;
    smp_stb_o    = (mode == SMP_ON_FALL) ? fall : rise;
    launch_stb_o = (mode == SMP_ON_FALL) ? rise : fall;
    start_o      = smp_stb_o & ws_seen & (ws_q != ws_last) & (ws_q == cfg_pol_i);
  end
endmodule

// File: rtl/audio_framer_slot.sv
module audio_framer_slot #(
  parameter int SAMPLE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid_i,
  input  logic [SAMPLE_W-1:0] in_data_i,
  output logic                in_ready_o,
  input  logic                take_i,
  input  logic                urun_clr_i,
  output logic                urun_o,
  output logic [SAMPLE_W-1:0] cur_o
);
  logic [SAMPLE_W-1:0] slot_q, last_q;
  logic                slot_valid;

  assign in_ready_o = ~slot_valid;
  assign cur_o      = slot_valid ? slot_q : last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q     <= '0;
      last_q     <= '0;
      slot_valid <= 1'b0;
      urun_o     <= 1'b0;
    end else begin
      if (urun_clr_i) urun_o <= 1'b0;
      if (take_i) begin
        if (slot_valid) last_q <= slot_q;
        else            urun_o <= 1'b1;
        slot_valid <= 1'b0;
      end
      if (in_valid_i && in_ready_o) begin
        slot_q     <= in_data_i;
        slot_valid <= 1'b1;
      end
    end
  end

  assert_ready_drop_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid_i && in_ready_o) |=> !in_ready_o);
  assert_underrun_set_R7: assert property (@(posedge clk) disable iff (rst)
    (take_i && !slot_valid) |=> urun_o);
endmodule

// File: rtl/audio_framer_shifter.sv
module audio_framer_shifter #(
  parameter int FRAME_MAX = 16,
  parameter int CNT_W     = $clog2(FRAME_MAX + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start_i,
  input  logic                 launch_i,
  input  logic [CNT_W-1:0]     len_i,
  input  logic [FRAME_MAX-1:0] word_i,
  output logic                 load_o,
  output logic                 sd_o
);
  logic                 pend, active;
  logic [FRAME_MAX-1:0] shreg;
  logic [CNT_W-1:0]     cnt;

  assign load_o = launch_i & pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend   <= 1'b0;
      active <= 1'b0;
      shreg  <= '0;
      cnt    <= '0;
      sd_o   <= 1'b0;
    end else begin
      if (start_i) pend <= 1'b1;
      if (launch_i) begin
        if (pend) begin
          pend   <= 1'b0;
          active <= 1'b1;
          sd_o   <= word_i[FRAME_MAX-1];
          shreg  <= word_i << 1;
          cnt    <= CNT_W'(1);
        end else if (active) begin
          if (cnt >= len_i) begin
            active <= 1'b0;
            sd_o   <= 1'b0;
          end else begin
            sd_o  <= shreg[FRAME_MAX-1];
            shreg <= shreg << 1;
            cnt   <= cnt + CNT_W'(1);
          end
        end
      end
    end
  end

  assert_sd_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !launch_i |=> $stable(sd_o));
  assert_count_bound_R4: assert property (@(posedge clk) disable iff (rst)
    active |-> (cnt != '0) && (cnt <= len_i));
  assert_load_msb_R5: assert property (@(posedge clk) disable iff (rst)
    load_o |=> (sd_o == $past(word_i[FRAME_MAX-1])));
endmodule

// File: rtl/audio_framer.sv
module audio_framer #(
  parameter int SAMPLE_W  = 8,
  parameter int FRAME_MAX = 16,
  parameter int LEN_W     = $clog2(FRAME_MAX)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sck_i,
  input  logic                ws_i,
  input  logic                cfg_pol_i,
  input  logic                cfg_edge_i,
  input  logic [LEN_W-1:0]    cfg_len_i,
  input  logic                in_valid_i,
  output logic                in_ready_o,
  input  logic [SAMPLE_W-1:0] in_data_i,
  input  logic                urun_clr_i,
  output logic                urun_o,
  output logic                sd_o
);
  localparam int CNT_W = $clog2(FRAME_MAX + 1);

  logic                 smp_stb, launch_stb, start, load;
  logic [SAMPLE_W-1:0]  cur;
  logic [FRAME_MAX-1:0] word;
  logic [CNT_W-1:0]     len;

  assign len = CNT_W'(cfg_len_i) + CNT_W'(1);

  generate
    if (FRAME_MAX > SAMPLE_W) begin : g_pad
      assign word = {cur, {(FRAME_MAX - SAMPLE_W){1'b0}}};
    end else begin : g_exact
      assign word = cur;
    end
  endgenerate

  audio_framer_edges u_edges (
    .clk          (clk),
    .rst          (rst),
    .sck_i        (sck_i),
    .ws_i         (ws_i),
    .cfg_pol_i    (cfg_pol_i),
    .cfg_edge_i   (cfg_edge_i),
    .smp_stb_o    (smp_stb),
    .launch_stb_o (launch_stb),
    .start_o      (start)
  );

  audio_framer_slot #(.SAMPLE_W(SAMPLE_W)) u_slot (
    .clk        (clk),
    .rst        (rst),
    .in_valid_i (in_valid_i),
    .in_data_i  (in_data_i),
    .in_ready_o (in_ready_o),
    .take_i     (load),
    .urun_clr_i (urun_clr_i),
    .urun_o     (urun_o),
    .cur_o      (cur)
  );

  audio_framer_shifter #(.FRAME_MAX(FRAME_MAX), .CNT_W(CNT_W)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start),
    .launch_i (launch_stb),
    .len_i    (len),
    .word_i   (word),
    .load_o   (load),
    .sd_o     (sd_o)
  );

  assert_edge_excl_R3: assert property (@(posedge clk) disable iff (rst)
    !(smp_stb && launch_stb));
endmodule

// File: tb/audio_framer_bench.sv
module audio_framer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 4;
  localparam int SW         = 8;
  localparam int FW         = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sck_i = 1'b0, ws_i = 1'b0, cfg_pol = 1'b1, cfg_edge = 1'b0;
  logic [3:0] cfg_len = '0;
  logic in_valid = 1'b0, urun_clr = 1'b0;
  logic [SW-1:0] in_data = '0;
  logic in_ready, urun, sd;
  logic got_a, got_b;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  audio_framer u_audio_framer (
    .clk(clk), .rst(rst), .sck_i(sck_i), .ws_i(ws_i),
    .cfg_pol_i(cfg_pol), .cfg_edge_i(cfg_edge), .cfg_len_i(cfg_len),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_data_i(in_data),
    .urun_clr_i(urun_clr), .urun_o(urun), .sd_o(sd)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (pol=%0d edge=%0d len=%0d)",
               req, act, exp, cfg_pol, cfg_edge, cfg_len + 1);
    end
  endtask

  // one bit-clock period: changing half first, then sampling half
  task automatic period(input logic ws_v);
    sck_i = ~cfg_edge;
    sck_i = cfg_edge;
    ws_i  = ws_v;
    repeat (HALF) @(negedge clk);
    got_a = sd;
    sck_i = ~cfg_edge;
    repeat (HALF) @(negedge clk);
    got_b = sd;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    sck_i = ~cfg_edge;
    ws_i  = ~cfg_pol;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic push(input logic [SW-1:0] d);
    in_valid = 1'b1;
    in_data  = d;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // frame start then len+2 bit periods checked against the arithmetic word
  task automatic frame(input logic [SW-1:0] samp, input bit exp_urun);
    logic [FW-1:0] ew;
    int len;
    ew  = {samp, {(FW-SW){1'b0}}};
    len = int'(cfg_len) + 1;
    period(cfg_pol);
    for (int k = 0; k < len + 2; k++) begin
      period(k == 0 ? cfg_pol : ~cfg_pol);
      if (k < len) check("R5 frame bit", int'(got_a), int'(ew[FW-1-k]));
      else         check("R4 after frame end", int'(got_a), 0);
      check("R3 stable over sampling edge", int'(got_b), int'(got_a));
    end
    check("R7 underrun flag", int'(urun), int'(exp_urun));
  endtask

  initial begin
    do_reset();
    check("R1 sd reset", int'(sd), 0);
    check("R1 urun reset", int'(urun), 0);
    check("R1 ready reset", int'(in_ready), 1);

    // R2 R3 R4 R5: full sweep of polarity, edge mode and length
    for (int p = 0; p < 2; p++) begin
      for (int e = 0; e < 2; e++) begin
        for (int d = 0; d < 16; d++) begin
          logic [SW-1:0] s;
          cfg_pol  = p[0];
          cfg_edge = e[0];
          cfg_len  = d[3:0];
          s = SW'(d * 37 + p * 5 + e * 11 + 1);
          do_reset();
          period(~cfg_pol);
          period(~cfg_pol);
          check("R2 no output before start", int'(got_a), 0);
          push(s);
          check("R6 ready low while slot full", int'(in_ready), 0);
          frame(s, 1'b0);
          check("R6 ready after frame take", int'(in_ready), 1);
        end
      end
    end

    // R8: restart in mid frame
    cfg_pol = 1'b1; cfg_edge = 1'b0; cfg_len = 4'd15;
    do_reset();
    period(1'b0); period(1'b0);
    push(8'hC3);
    period(1'b1);
    period(1'b1); check("R8 first frame bit0", int'(got_a), 1);
    period(1'b0); check("R8 first frame bit1", int'(got_a), 1);
    period(1'b0); check("R8 first frame bit2", int'(got_a), 0);
    push(8'h5A);
    period(1'b1); check("R8 first frame bit3", int'(got_a), 0);
    for (int k = 0; k < 17; k++) begin
      logic [FW-1:0] ew;
      ew = {8'h5A, 8'h00};
      period(k == 0 ? 1'b1 : 1'b0);
      check("R8 restarted bit", int'(got_a), k < 16 ? int'(ew[FW-1-k]) : 0);
    end
    check("R8 no underrun", int'(urun), 0);

    // R7: underrun repeats sample, flag sticky until cleared
    cfg_pol = 1'b0; cfg_edge = 1'b1; cfg_len = 4'd11;
    do_reset();
    period(1'b1); period(1'b1);
    push(8'hA5);
    frame(8'hA5, 1'b0);
    period(1'b1);
    frame(8'hA5, 1'b1);
    repeat (3) @(negedge clk);
    check("R7 flag held", int'(urun), 1);
    urun_clr = 1'b1;
    @(negedge clk);
    urun_clr = 1'b0;
    check("R7 flag cleared", int'(urun), 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule